// File: doc/BRIEF.md
# Parallel-Port Mode Negotiation Controller

This block is the host-side sequencer that moves a parallel-port link out of its power-up compatibility mode into an extended operating mode. On a start request it captures an 8-bit request code and drives that code onto the data lines. It then signals the start of negotiation on the select and feed control lines and waits for the peripheral to show a fixed four-line status signature. It pulses the strobe line, waits for the peripheral to raise its acknowledge line, and then reads the status lines to decide whether the requested mode was granted.

The outcome is reported with a one-cycle `done` pulse and a 2-bit result. A peripheral that never shows the signature, or never raises acknowledge, is classed as a legacy device. When a mode is granted the block holds the link in that mode until the user asks to leave. It then performs the exit that suits the granted mode: the reset line for the address/data-strobe mode (request 0x40), and the select line for every other mode. All peripheral inputs are assumed to be already synchronous to `clk`.

Top module: `pp_mode_negotiator`

## Requirements
- R1: During and right after reset: `lnk_sel_n`=0, `lnk_feed_n`=1, `lnk_strobe_n`=1, `lnk_init_n`=1, `done`=0, `result`=0, `mode_active`=0.
- R2: A `start` pulse in idle latches `req_code` onto `lnk_data` on the next clock. The data is held with `lnk_sel_n` low for exactly SETUP_CYC cycles. After that, `lnk_sel_n` goes high and `lnk_feed_n` goes low together.
- R3: `lnk_strobe_n` falls only after the peripheral shows the signature `prf_paper`=1, `prf_ack_n`=0, `prf_fault_n`=1, `prf_online`=1. It also does not fall until the request phase has lasted at least SETUP_CYC cycles.
- R4: If the signature does not appear within TIMEOUT_CYC cycles, the block reports result 2'b01 (legacy) and returns the lines to the R1 idle levels.
- R5: `lnk_strobe_n` stays low for exactly STROBE_CYC cycles. Throughout that time `lnk_sel_n`=1, `lnk_feed_n`=0 and `lnk_data` is stable. `lnk_strobe_n` and `lnk_feed_n` then return high on the same clock.
- R6: After the strobe, no result is given while `prf_ack_n` is low. On the clock where `prf_ack_n` is seen high, the status is sampled. If `prf_paper`=0, `prf_fault_n`=0 and `prf_online`=1, the result is 2'b10 (accepted) and `mode_active` goes to 1.
- R7: Any other status at that sample gives result 2'b11 (rejected). In that case `mode_active` stays 0 and the lines return to idle levels.
- R8: If `prf_ack_n` does not go high within TIMEOUT_CYC cycles after the strobe, the result is 2'b01.
- R9: Each negotiation produces exactly one `done` pulse, one cycle long. `result` is nonzero while `done` is high and holds until the next outcome.
- R10: `exit_req` in the active mode with a latched code of 0x40 drives `lnk_init_n` low for exactly SETUP_CYC cycles with `lnk_sel_n` high. After that the lines return to idle.
- R11: `exit_req` in the active mode with any other code drives `lnk_sel_n` low on the next clock. `lnk_init_n` stays high and `mode_active` clears.
- R12: `start` outside idle has no effect on `lnk_data` or the sequence. `exit_req` outside the active mode has no effect on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin negotiation (idle only) |
| req_code | input | 8 | Extensibility request code |
| exit_req | input | 1 | Leave the granted mode (active only) |
| done | output | 1 | One-cycle outcome strobe |
| result | output | 2 | 01 legacy, 10 accepted, 11 rejected |
| mode_active | output | 1 | Link is in the granted mode |
| lnk_data | output | 8 | Data lines to peripheral |
| lnk_sel_n | output | 1 | Select control line, active low |
| lnk_feed_n | output | 1 | Feed control line, active low |
| lnk_strobe_n | output | 1 | Strobe line, active low |
| lnk_init_n | output | 1 | Peripheral reset line, active low |
| prf_paper | input | 1 | Paper-status line from peripheral |
| prf_ack_n | input | 1 | Acknowledge line, active low |
| prf_fault_n | input | 1 | Fault line, active low |
| prf_online | input | 1 | Online/selected line |

## Verification
The assertions check four things on every cycle:
- the strobe only ever falls after the signature was present on the previous clock;
- the control levels and the data stay fixed while the strobe is low;
- an accept is only ever reported after acknowledge was seen high, and `done` never lasts two cycles;
- the reset line is only driven low with select high and the mode inactive.

Exact cycle counts need the bench's peripheral scenarios to show them. These are the setup length, the strobe width and the exit-pulse width. The bench also covers both timeout outcomes, the result for each request code and reply, and the fact that ignored `start` and `exit_req` pulses leave the lines untouched.

// File: rtl/pp_neg_pkg.sv
package pp_neg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_SIG,
    ST_STB_LO,
    ST_WAIT_ACK,
    ST_ACTIVE,
    ST_EXIT
  } neg_state_e;

  localparam logic [1:0] RES_NONE   = 2'b00;
  localparam logic [1:0] RES_LEGACY = 2'b01;
  localparam logic [1:0] RES_ACCEPT = 2'b10;
  localparam logic [1:0] RES_REJECT = 2'b11;

  // request code whose mode is left through the reset line
  localparam logic [7:0] REQ_ADDR_DATA_MODE = 8'h40;

  typedef struct packed {
    logic sel_n;
    logic feed_n;
    logic strobe_n;
    logic init_n;
  } pin_ctl_t;

  localparam pin_ctl_t PINS_IDLE = '{sel_n: 1'b0, feed_n: 1'b1, strobe_n: 1'b1, init_n: 1'b1};

endpackage

// File: rtl/pp_neg_cycle_ctr.sv
module pp_neg_cycle_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic [W-1:0] count_d;
  logic         count_en;

  always_comb begin
    count_en = clear || (count != CMAX);
    count_d  = clear ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end

endmodule

// File: rtl/pp_neg_status_decode.sv
module pp_neg_status_decode (
  input  logic prf_paper,
  input  logic prf_ack_n,
  input  logic prf_fault_n,
  input  logic prf_online,
  output logic sig_present,
  output logic grant,
  output logic ack_high
);

  always_comb begin
    sig_present = prf_paper && !prf_ack_n && prf_fault_n && prf_online;
    grant       = !prf_paper && !prf_fault_n && prf_online;
    ack_high    = prf_ack_n;
  end

endmodule

// File: rtl/pp_neg_pin_map.sv
module pp_neg_pin_map
  import pp_neg_pkg::*;
(
  input  neg_state_e st,
  input  logic       exit_by_init,
  output pin_ctl_t   ctl
);

  always_comb begin
    ctl = PINS_IDLE;
    unique case (st)
      ST_IDLE, ST_SETUP: ctl = PINS_IDLE;
      ST_WAIT_SIG: begin
        ctl.sel_n  = 1'b1;
        ctl.feed_n = 1'b0;
      end
      ST_STB_LO: begin
        ctl.sel_n    = 1'b1;
        ctl.feed_n   = 1'b0;
        ctl.strobe_n = 1'b0;
      end
      ST_WAIT_ACK, ST_ACTIVE: ctl.sel_n = 1'b1;
      ST_EXIT: begin
        if (exit_by_init) begin
          ctl.sel_n  = 1'b1;
          ctl.init_n = 1'b0;
        end else begin
          ctl.sel_n  = 1'b0;
        end
      end
      default: ctl = PINS_IDLE;
    endcase
  end

endmodule

// File: rtl/pp_mode_negotiator.sv
module pp_mode_negotiator
  import pp_neg_pkg::*;
#(
  parameter int SETUP_CYC   = 4,
  parameter int STROBE_CYC  = 3,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] req_code,
  input  logic       exit_req,
  output logic       done,
  output logic [1:0] result,
  output logic       mode_active,
  output logic [7:0] lnk_data,
  output logic       lnk_sel_n,
  output logic       lnk_feed_n,
  output logic       lnk_strobe_n,
  output logic       lnk_init_n,
  input  logic       prf_paper,
  input  logic       prf_ack_n,
  input  logic       prf_fault_n,
  input  logic       prf_online
);

  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAXC  = (TIMEOUT_CYC > MAX_A) ? TIMEOUT_CYC : MAX_A;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] STB_LAST   = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);

  neg_state_e state_q, state_d;
  logic [7:0] code_q, code_d;
  logic       code_en;
  logic [1:0] res_q, res_d;
  logic       decide;
  logic       done_q;
  logic       active_q;
  pin_ctl_t   pins_q, pins_d;
  logic [CW-1:0] cnt;
  logic       sig_present, grant, ack_high;

  pp_neg_cycle_ctr #(.W(CW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_d != state_q),
    .count (cnt)
  );

  pp_neg_status_decode u_dec (
    .prf_paper   (prf_paper),
    .prf_ack_n   (prf_ack_n),
    .prf_fault_n (prf_fault_n),
    .prf_online  (prf_online),
    .sig_present (sig_present),
    .grant       (grant),
    .ack_high    (ack_high)
  );

  pp_neg_pin_map u_map (
    .st           (state_d),
    .exit_by_init (code_q == REQ_ADDR_DATA_MODE),
    .ctl          (pins_d)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    code_d  = req_code;
    code_en = 1'b0;
    res_d   = res_q;
    decide  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        code_en = 1'b1;
        state_d = ST_SETUP;
      end
      ST_SETUP: if (cnt == SETUP_LAST) state_d = ST_WAIT_SIG;
      ST_WAIT_SIG: begin
        if (sig_present && cnt >= SETUP_LAST) begin
          state_d = ST_STB_LO;
        end else if (cnt >= TMO_LAST) begin
          decide  = 1'b1;
          res_d   = RES_LEGACY;
          state_d = ST_IDLE;
        end
      end
      ST_STB_LO: if (cnt == STB_LAST) state_d = ST_WAIT_ACK;
      ST_WAIT_ACK: begin
        if (ack_high) begin
          decide  = 1'b1;
          res_d   = grant ? RES_ACCEPT : RES_REJECT;
          state_d = grant ? ST_ACTIVE : ST_IDLE;
        end else if (cnt >= TMO_LAST) begin
          decide  = 1'b1;
          res_d   = RES_LEGACY;
          state_d = ST_IDLE;
        end
      end
      ST_ACTIVE: if (exit_req) state_d = ST_EXIT;
      ST_EXIT:   if (cnt == SETUP_LAST) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      res_q    <= RES_NONE;
      done_q   <= 1'b0;
      active_q <= 1'b0;
      pins_q   <= PINS_IDLE;
    end else begin
      state_q  <= state_d;
      if (code_en) code_q <= code_d;
      if (decide)  res_q  <= res_d;
      done_q   <= decide;
      active_q <= (state_d == ST_ACTIVE);
      pins_q   <= pins_d;
    end
  end

  assign done         = done_q;
  assign result       = res_q;
  assign mode_active  = active_q;
  assign lnk_data     = code_q;
  assign lnk_sel_n    = pins_q.sel_n;
  assign lnk_feed_n   = pins_q.feed_n;
  assign lnk_strobe_n = pins_q.strobe_n;
  assign lnk_init_n   = pins_q.init_n;

  // assertions
  AST_STROBE_AFTER_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lnk_strobe_n) |-> $past(prf_paper && !prf_ack_n && prf_fault_n && prf_online)); // R3
  AST_STROBE_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_strobe_n |-> (lnk_sel_n && !lnk_feed_n && $stable(lnk_data))); // R5
  AST_ACCEPT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_ACCEPT) |-> ($past(prf_ack_n) && mode_active)); // R6
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_REJECT) |-> (!lnk_sel_n && !mode_active)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != RES_NONE)); // R9
  AST_INIT_EXIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_init_n |-> (lnk_sel_n && !mode_active)); // R10

endmodule

// File: tb/pp_mode_negotiator_tb.sv
`timescale 1ns/1ps
module pp_mode_negotiator_tb;

  localparam int SETUP_CYC   = 4;
  localparam int STROBE_CYC  = 3;
  localparam int TIMEOUT_CYC = 64;

  // {code[7:0], compliant, grants, expected result[1:0]}
  localparam logic [11:0] VEC [7] = '{
    {8'h40, 1'b1, 1'b1, 2'b10},
    {8'h10, 1'b1, 1'b1, 2'b10},
    {8'h20, 1'b1, 1'b0, 2'b11},
    {8'h00, 1'b1, 1'b1, 2'b10},
    {8'h01, 1'b1, 1'b0, 2'b11},
    {8'h04, 1'b0, 1'b0, 2'b01},
    {8'h80, 1'b1, 1'b1, 2'b10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic exit_req = 1'b0;
  logic done, mode_active;
  logic [1:0] result;
  logic [7:0] lnk_data;
  logic lnk_sel_n, lnk_feed_n, lnk_strobe_n, lnk_init_n;
  logic prf_paper = 1'b0, prf_ack_n = 1'b1, prf_fault_n = 1'b1, prf_online = 1'b1;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pp_mode_negotiator #(
    .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_code(req_code), .exit_req(exit_req),
    .done(done), .result(result), .mode_active(mode_active), .lnk_data(lnk_data),
    .lnk_sel_n(lnk_sel_n), .lnk_feed_n(lnk_feed_n), .lnk_strobe_n(lnk_strobe_n),
    .lnk_init_n(lnk_init_n), .prf_paper(prf_paper), .prf_ack_n(prf_ack_n),
    .prf_fault_n(prf_fault_n), .prf_online(prf_online)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic prf_idle();
    prf_paper = 1'b0; prf_ack_n = 1'b1; prf_fault_n = 1'b1; prf_online = 1'b1;
  endtask

  task automatic idle_lines(input string tag);
    chk(lnk_sel_n == 0 && lnk_feed_n == 1 && lnk_strobe_n == 1 && lnk_init_n == 1,
        tag, {lnk_sel_n, lnk_feed_n, lnk_strobe_n, lnk_init_n}, 4'b0111);
  endtask

  task automatic wait_done(output int seen);
    int n = 0;
    while (done !== 1'b1 && n < TIMEOUT_CYC + 40) begin @(negedge clk); n++; end
    seen = (done === 1'b1);
  endtask

  task automatic run_neg(input logic [7:0] code, input bit comp, input bit acc,
                         input bit ackok, input bit poke, input logic [1:0] exp);
    int n, bad, seen;
    @(negedge clk); req_code = code; start = 1'b1;
    @(negedge clk); start = 1'b0; req_code = 8'hAA;
    n = 0;
    while (lnk_sel_n == 1'b0 && n < 100) begin n++; @(negedge clk); end
    chk(n == SETUP_CYC, "R2 setup length", n, SETUP_CYC);
    chk(lnk_data == code, "R2 data latched", lnk_data, code);
    chk(lnk_feed_n == 1'b0, "R2 feed low with select high", lnk_feed_n, 0);
    if (poke) begin
      req_code = 8'h55; start = 1'b1; @(negedge clk); start = 1'b0;
    end
    bad = 0;
    repeat (3) begin if (lnk_strobe_n == 1'b0) bad++; @(negedge clk); end
    chk(bad == 0, "R3 no strobe before signature", bad, 0);
    if (!comp) begin
      wait_done(seen);
      chk(seen == 1 && result == 2'b01, "R4 legacy result", result, 1);
      idle_lines("R4 lines back to idle");
      @(negedge clk);
      chk(done == 0, "R9 done single cycle", done, 0);
      return;
    end
    prf_paper = 1'b1; prf_ack_n = 1'b0; prf_fault_n = 1'b1; prf_online = 1'b1;
    n = 0;
    while (lnk_strobe_n == 1'b1 && n < 50) begin n++; @(negedge clk); end
    n = 0; bad = 0;
    while (lnk_strobe_n == 1'b0 && n < 50) begin
      if (!(lnk_sel_n == 1 && lnk_feed_n == 0 && lnk_data == code)) bad++;
      n++; @(negedge clk);
    end
    chk(n == STROBE_CYC, "R5 strobe width", n, STROBE_CYC);
    chk(bad == 0, "R5 levels during strobe", bad, 0);
    chk(lnk_feed_n == 1'b1, "R5 feed released with strobe", lnk_feed_n, 1);
    if (poke) chk(lnk_data == code, "R12 start ignored when busy", lnk_data, code);
    if (acc) begin prf_paper = 1'b0; prf_fault_n = 1'b0; end
    bad = 0;
    repeat (3) begin @(negedge clk); if (done) bad++; end
    chk(bad == 0, "R6 no result while ack low", bad, 0);
    if (ackok) prf_ack_n = 1'b1;
    wait_done(seen);
    chk(seen == 1 && result == exp, ackok ? "R6 R7 negotiated result" : "R8 ack timeout",
        result, exp);
    @(negedge clk);
    chk(done == 0, "R9 done single cycle", done, 0);
    chk(mode_active == (exp == 2'b10), "R6 R7 mode_active", mode_active, exp == 2'b10);
    if (exp != 2'b10) idle_lines("R7 lines back to idle");
    chk(result == exp, "R9 result held", result, exp);
    prf_idle();
  endtask

  task automatic run_exit(input logic [7:0] code);
    int n, bad;
    @(negedge clk); exit_req = 1'b1;
    @(negedge clk); exit_req = 1'b0;
    if (code == 8'h40) begin
      n = 0; bad = 0;
      while (lnk_init_n == 1'b0 && n < 50) begin
        if (lnk_sel_n != 1'b1) bad++;
        n++; @(negedge clk);
      end
      chk(n == SETUP_CYC, "R10 init pulse length", n, SETUP_CYC);
      chk(bad == 0, "R10 select high during init", bad, 0);
      idle_lines("R10 idle after exit");
    end else begin
      chk(lnk_sel_n == 1'b0 && mode_active == 1'b0, "R11 select low on exit",
          lnk_sel_n, 0);
      bad = 0;
      repeat (SETUP_CYC + 2) begin if (lnk_init_n == 1'b0) bad++; @(negedge clk); end
      chk(bad == 0, "R11 init stays high", bad, 0);
      idle_lines("R11 idle after exit");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    idle_lines("R1 lines in reset");
    chk(done == 0 && result == 0 && mode_active == 0, "R1 outputs in reset",
        {done, result, mode_active}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_lines("R1 lines after reset");
    chk(done == 0 && result == 0 && mode_active == 0, "R1 outputs after reset",
        {done, result, mode_active}, 0);

    for (int i = 0; i < 7; i++) begin
      run_neg(VEC[i][11:4], VEC[i][3], VEC[i][2], 1'b1, 1'b0, VEC[i][1:0]);
      if (VEC[i][1:0] == 2'b10) run_exit(VEC[i][11:4]);
    end

    // R8: peripheral never raises acknowledge
    run_neg(8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01);

    // R12: start during negotiation is ignored
    run_neg(8'h01, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11);

    // R12: exit request in idle changes nothing
    @(negedge clk); exit_req = 1'b1;
    @(negedge clk); exit_req = 1'b0;
    bad = 0;
    repeat (6) begin
      if (!(lnk_sel_n == 0 && lnk_init_n == 1 && mode_active == 0)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R12 exit ignored in idle", bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule